// File: doc/BRIEF.md
# Performance Counter Register Bank

This block is a compact bank of performance-monitoring registers. It keeps a set of general-purpose event counters, each paired with its own event-select register, plus three fixed-function counters. One packed control word configures all three fixed counters. A 4-bit sampling-enable register completes the configuration. Software reaches every register through a single-port address/data interface. Reads are registered and return data one cycle after the request. Each counter advances on its own event strobe while its configuration marks it active.

A counter can be written in two ways. The narrow, legacy address takes the low 32 bits of the write data and sign-extends them. When the full-width capability strap is set, a second alias address range starting at 0x4C1 also reaches each counter, and it stores the full write data. A read-only status word summarises the configuration. It is rebuilt every cycle from the event-select registers, the fixed-control word and the sampling-enable bits, and it reports which counters are claimed and whether any overflow interrupt source is armed.

Top module: `pmc_regfile`

## Requirements
- R1: After a synchronous active-high reset, every counter, event-select register, the fixed-control word, the sampling-enable register and `rdata` are zero.
- R2: A write to general-purpose counter i at address 0x100+i stores the 32-bit `wdata[31:0]` sign-extended from bit 31, truncated to CTR_W bits. A write to fixed counter j at 0x180+j stores `wdata` truncated to CTR_W bits. Counter reads return the value zero-extended to 64 bits.
- R3: With `cap_full_write`=1, address 0x4C1+i reads general-purpose counter i, and a write there stores `wdata` truncated to CTR_W bits without sign extension.
- R4: With `cap_full_write`=0, alias addresses read 0 and writes to them leave the counters unchanged. The capability register at 0x1C3 reads bit 13 equal to `cap_full_write` and 0 in all other bits, and it ignores writes.
- R5: Bit n of the status word at 0x1C2 is 1 exactly when bits [7:0] of event-select n (address 0x140+n, 32 bits stored) are nonzero, for n < N. Bits N..31 read 0.
- R6: The fixed-control word (0x1C0, 12 bits) holds a 4-bit field per fixed counter j at bits [4j+3:4j]. Status bits 32, 33 and 34 are 1 when bits [1:0], [5:4] and [9:8] respectively are nonzero.
- R7: Status bit 63 is 1 when any event-select bit 20 is set, or any fixed-control bit 3, 7 or 11 is set, or any bit of the sampling-enable register (0x1C1, bits [3:0] stored, upper bits dropped) is set. Bits 35..62 read 0.
- R8: The status word is read-only. Writes to 0x1C2 change no register.
- R9: A general-purpose counter whose event-select bits [7:0] are nonzero, or a fixed counter whose field bits [1:0] are nonzero, adds one per cycle in which its strobe is high, and it wraps from 2^CTR_W-1 to 0. A counter with a zero enable field holds its value.
- R10: When a software write and an event strobe hit the same counter in the same cycle, the written value is stored and the strobe is lost.
- R11: `rdata` updates one cycle after a cycle with `rd_en`=1. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_full_write | input | 1 | Strap that enables the full-width alias range |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (12) | Register address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read data |
| gp_evt | input | N (4) | Event strobes, one per general-purpose counter |
| fx_evt | input | 3 | Event strobes, one per fixed counter |

## Verification
Legacy writes are tried with bit 31 both set and clear, and with junk in the upper data bits. These cases separate sign extension from zero extension and from passing the data straight through. Alias writes carry data wider than 32 bits and are tried with the capability strap both on and off, which shows whether the gate is really applied. Status-word patterns set one configuration field at a time: the select code alone, the interrupt bit alone, each fixed field, the fixed PMI bits alone, and a sampling-enable bit inside and outside the 4-bit range. Any crossed wire or wrong bit position therefore shows up as a wrong single bit. The counting cases cover wrap at full scale, a disabled counter, independent fixed counters, and a write that coincides with a strobe.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  // register map (word addresses)
  localparam int GP_BASE    = 'h100;
  localparam int EVSEL_BASE = 'h140;
  localparam int FX_BASE    = 'h180;
  localparam int FXCTL_ADDR = 'h1C0;
  localparam int SAMP_ADDR  = 'h1C1;
  localparam int INUSE_ADDR = 'h1C2;
  localparam int CAPS_ADDR  = 'h1C3;
  localparam int ALIAS_BASE = 'h4C1;

  localparam int NUM_FX     = 3;
  localparam int FXCTL_W    = 4 * NUM_FX;
  localparam int SAMP_W     = 4;
  localparam int EVSEL_W    = 32;
  localparam int CAP_BIT    = 13;
  localparam int PMI_BIT    = 63;
  localparam int FX_USE_LSB = 32;

  // narrow write: sign-extend low 32 bits to 64
  function automatic logic [63:0] sext32(input logic [63:0] d);
    return {{32{d[31]}}, d[31:0]};
  endfunction
endpackage

// File: rtl/pmc_ctr.sv
module pmc_ctr #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         cnt_en,
  input  logic         evt,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)                q <= '0;
    else if (wr_en)         q <= wr_val;
    else if (cnt_en && evt) q <= q + 1'b1;
  end

  // R10: software write wins over a same-cycle strobe
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> q == $past(wr_val));

  // R9: enabled strobe adds one, wrapping at W bits
  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && cnt_en && evt) |=> q == W'($past(q) + 1'b1));

  // R9: no write and no qualified strobe -> value holds
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !(cnt_en && evt)) |=> $stable(q));
endmodule

// File: rtl/pmc_inuse.sv
module pmc_inuse
  import pmc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N*EVSEL_W-1:0] evsel_flat,
  input  logic [FXCTL_W-1:0]   fxctl,
  input  logic [SAMP_W-1:0]    samp,
  output logic [63:0]          inuse
);
  logic [N-1:0]      int_bits;
  logic [NUM_FX-1:0] fx_pmi;
  logic unused_cfg;

  assign unused_cfg = ^{evsel_flat, fxctl};

  // general-purpose claim bits
  for (genvar b = 0; b < 32; b++) begin : g_gp
    if (b < N) begin : g_on
      assign inuse[b]    = |evsel_flat[b*EVSEL_W +: 8];
      assign int_bits[b] = evsel_flat[b*EVSEL_W + 20];
    end else begin : g_off
      assign inuse[b] = 1'b0;
    end
  end

  // fixed counter claim bits and PMI enables
  for (genvar j = 0; j < NUM_FX; j++) begin : g_fx
    assign inuse[FX_USE_LSB + j] = |fxctl[4*j +: 2];
    assign fx_pmi[j]             = fxctl[4*j + 3];
  end

  for (genvar b = FX_USE_LSB + NUM_FX; b < PMI_BIT; b++) begin : g_rsv
    assign inuse[b] = 1'b0;
  end

  assign inuse[PMI_BIT] = (|int_bits) | (|fx_pmi) | (|samp);
endmodule

// File: rtl/pmc_regfile.sv
module pmc_regfile
  import pmc_pkg::*;
#(
  parameter int N      = 4,
  parameter int CTR_W  = 48,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_full_write,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata,
  input  logic [N-1:0]      gp_evt,
  input  logic [NUM_FX-1:0] fx_evt
);
  initial begin
    if (N < 1 || N > 32)        $error("N out of range");
    if (CTR_W < 32 || CTR_W > 64) $error("CTR_W out of range");
  end

  logic [EVSEL_W-1:0]     evsel_q [N];
  logic [N*EVSEL_W-1:0]   evsel_flat;
  logic [FXCTL_W-1:0]     fxctl_q;
  logic [SAMP_W-1:0]      samp_q;
  logic [N-1:0][CTR_W-1:0]      gp_q;
  logic [NUM_FX-1:0][CTR_W-1:0] fx_q;
  logic [63:0]            inuse;
  logic [63:0]            narrow;
  logic [N-1:0]           alias_hit;
  logic                   alias_any;
  logic [63:0]            rd_val;
  logic                   rd_hit;

  assign narrow    = sext32(wdata);
  assign alias_any = |alias_hit;

  // configuration registers
  for (genvar i = 0; i < N; i++) begin : g_evsel
    always_ff @(posedge clk) begin
      if (rst) evsel_q[i] <= '0;
      else if (wr_en && addr == ADDR_W'(EVSEL_BASE + i)) evsel_q[i] <= wdata[EVSEL_W-1:0];
    end
    assign evsel_flat[i*EVSEL_W +: EVSEL_W] = evsel_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fxctl_q <= '0;
      samp_q  <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(FXCTL_ADDR)) fxctl_q <= wdata[FXCTL_W-1:0];
      if (addr == ADDR_W'(SAMP_ADDR))  samp_q  <= wdata[SAMP_W-1:0];
    end
  end

  // general-purpose counters: narrow and alias write paths
  for (genvar i = 0; i < N; i++) begin : g_gp
    logic legacy_hit;
    logic wr_i;
    logic [CTR_W-1:0] wv_i;
    assign legacy_hit   = addr == ADDR_W'(GP_BASE + i);
    assign alias_hit[i] = addr == ADDR_W'(ALIAS_BASE + i);
    assign wr_i = wr_en && (legacy_hit || (cap_full_write && alias_hit[i]));
    assign wv_i = alias_hit[i] ? wdata[CTR_W-1:0] : narrow[CTR_W-1:0];

    pmc_ctr #(.W(CTR_W)) u_ctr (
      .clk(clk), .rst(rst), .wr_en(wr_i), .wr_val(wv_i),
      .cnt_en(|evsel_q[i][7:0]), .evt(gp_evt[i]), .q(gp_q[i])
    );
  end

  // fixed counters
  for (genvar j = 0; j < NUM_FX; j++) begin : g_fx
    logic wr_j;
    assign wr_j = wr_en && addr == ADDR_W'(FX_BASE + j);
    pmc_ctr #(.W(CTR_W)) u_ctr (
      .clk(clk), .rst(rst), .wr_en(wr_j), .wr_val(wdata[CTR_W-1:0]),
      .cnt_en(|fxctl_q[4*j +: 2]), .evt(fx_evt[j]), .q(fx_q[j])
    );
  end

  if (CTR_W < 64) begin : g_unused_hi
    logic unused_hi;
    assign unused_hi = ^wdata[63:CTR_W];
  end

  // live status word
  pmc_inuse #(.N(N)) u_inuse (
    .evsel_flat(evsel_flat), .fxctl(fxctl_q), .samp(samp_q), .inuse(inuse)
  );

  // read decode
  always_comb begin
    rd_val = '0;
    rd_hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (addr == ADDR_W'(GP_BASE + i)) begin
        rd_val = 64'(gp_q[i]);
        rd_hit = 1'b1;
      end
      if (addr == ADDR_W'(EVSEL_BASE + i)) begin
        rd_val = 64'(evsel_q[i]);
        rd_hit = 1'b1;
      end
      if (alias_hit[i]) begin
        rd_val = cap_full_write ? 64'(gp_q[i]) : '0;
        rd_hit = 1'b1;
      end
    end
    for (int j = 0; j < NUM_FX; j++) begin
      if (addr == ADDR_W'(FX_BASE + j)) begin
        rd_val = 64'(fx_q[j]);
        rd_hit = 1'b1;
      end
    end
    if (addr == ADDR_W'(FXCTL_ADDR)) begin
      rd_val = 64'(fxctl_q);
      rd_hit = 1'b1;
    end
    if (addr == ADDR_W'(SAMP_ADDR)) begin
      rd_val = 64'(samp_q);
      rd_hit = 1'b1;
    end
    if (addr == ADDR_W'(INUSE_ADDR)) begin
      rd_val = inuse;
      rd_hit = 1'b1;
    end
    if (addr == ADDR_W'(CAPS_ADDR)) begin
      rd_val = 64'(cap_full_write) << CAP_BIT;
      rd_hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  // R4: gated alias write leaves every counter untouched
  a_r4_alias_write_gated: assert property (@(posedge clk) disable iff (rst)
    (wr_en && alias_any && !cap_full_write && gp_evt == '0) |=> $stable(gp_q));

  // R4: gated alias read returns zero
  a_r4_alias_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && alias_any && !cap_full_write) |=> rdata == '0);

  // R8: status-word write disturbs no configuration
  a_r8_inuse_ro: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(INUSE_ADDR)) |=> ($stable(fxctl_q) && $stable(samp_q) && $stable(evsel_flat)));

  // R11: unmapped read returns zero next cycle
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_hit) |=> rdata == '0);

  // R11: rdata holds without a read request
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_pmc_regfile.sv
module sim_pmc_regfile;
  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int CW    = 48;
  localparam logic [63:0] MASK = (64'h1 << CW) - 1;

  localparam logic [11:0] A_GP    = 12'h100;
  localparam logic [11:0] A_EVSEL = 12'h140;
  localparam logic [11:0] A_FX    = 12'h180;
  localparam logic [11:0] A_FXCTL = 12'h1C0;
  localparam logic [11:0] A_SAMP  = 12'h1C1;
  localparam logic [11:0] A_INUSE = 12'h1C2;
  localparam logic [11:0] A_CAPS  = 12'h1C3;
  localparam logic [11:0] A_ALIAS = 12'h4C1;

  logic clk = 0, rst = 1, cap = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic [N-1:0] gp_evt = '0;
  logic [2:0] fx_evt = '0;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pmc_regfile #(.N(N), .CTR_W(CW), .ADDR_W(12)) u0 (
    .clk(clk), .rst(rst), .cap_full_write(cap), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .gp_evt(gp_evt), .fx_evt(fx_evt)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [63:0] exp);
    logic [63:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic pulse(input logic [N-1:0] g, input logic [2:0] f);
    @(negedge clk); gp_evt = g; fx_evt = f;
    @(negedge clk); gp_evt = '0; fx_evt = '0;
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < N; i++) wr(A_EVSEL + 12'(i), 64'h0);
    wr(A_FXCTL, 64'h0);
    wr(A_SAMP, 64'h0);
  endtask

  task automatic t_reset();
    rd_chk("R1 rdata after reset", A_GP, 64'h0);
    rd_chk("R1 evsel0", A_EVSEL, 64'h0);
    rd_chk("R1 fixed ctl", A_FXCTL, 64'h0);
    rd_chk("R1 status word", A_INUSE, 64'h0);
    rd_chk("R1 fixed ctr2", A_FX + 12'd2, 64'h0);
  endtask

  task automatic t_legacy();
    wr(A_GP + 12'd1, 64'h0000_0000_8000_0001);
    rd_chk("R2 sign-extend negative", A_GP + 12'd1, 64'h0000_FFFF_8000_0001);
    wr(A_GP + 12'd1, 64'h1234_5678_7FFF_FFFF);
    rd_chk("R2 positive drops upper", A_GP + 12'd1, 64'h0000_0000_7FFF_FFFF);
    wr(A_FX + 12'd1, 64'hFFFF_1234_5678_9ABC);
    rd_chk("R2 fixed full write", A_FX + 12'd1, 64'h0000_1234_5678_9ABC);
  endtask

  task automatic t_alias_on();
    cap = 1;
    wr(A_ALIAS + 12'd1, 64'hABCD_1234_5678_9ABC);
    rd_chk("R3 alias write via legacy read", A_GP + 12'd1, 64'h0000_1234_5678_9ABC);
    rd_chk("R3 alias read", A_ALIAS + 12'd1, 64'h0000_1234_5678_9ABC);
    rd_chk("R4 caps bit13 set", A_CAPS, 64'h2000);
  endtask

  task automatic t_alias_off();
    cap = 0;
    wr(A_GP + 12'd1, 64'h1111);
    wr(A_ALIAS + 12'd1, 64'h5);
    rd_chk("R4 gated alias write ignored", A_GP + 12'd1, 64'h1111);
    rd_chk("R4 gated alias reads zero", A_ALIAS + 12'd1, 64'h0);
    rd_chk("R4 caps bit13 clear", A_CAPS, 64'h0);
    wr(A_CAPS, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R4 caps ignores write", A_CAPS, 64'h0);
  endtask

  task automatic t_inuse_gp();
    clear_cfg();
    wr(A_EVSEL + 12'd2, 64'h100);
    rd_chk("R5 upper select bits only", A_INUSE, 64'h0);
    wr(A_EVSEL + 12'd2, 64'h01);
    rd_chk("R5 select code sets bit2", A_INUSE, 64'h4);
    wr(A_EVSEL + 12'd0, 64'h0010_0000);
    rd_chk("R7 interrupt bit sets bit63", A_INUSE, 64'h8000_0000_0000_0004);
    wr(A_EVSEL + 12'd3, 64'hFF);
    rd_chk("R5 bit3 and nothing above N", A_INUSE, 64'h8000_0000_0000_000C);
  endtask

  task automatic t_inuse_fx();
    clear_cfg();
    wr(A_FXCTL, 64'h2);
    rd_chk("R6 field0 -> bit32", A_INUSE, 64'h0000_0001_0000_0000);
    wr(A_FXCTL, 64'h10);
    rd_chk("R6 field1 -> bit33", A_INUSE, 64'h0000_0002_0000_0000);
    wr(A_FXCTL, 64'h300);
    rd_chk("R6 field2 -> bit34", A_INUSE, 64'h0000_0004_0000_0000);
    wr(A_FXCTL, 64'h888);
    rd_chk("R7 fixed PMI bits -> bit63 only", A_INUSE, 64'h8000_0000_0000_0000);
    wr(A_FXCTL, 64'h0);
    wr(A_SAMP, 64'h4);
    rd_chk("R7 sampling bit -> bit63", A_INUSE, 64'h8000_0000_0000_0000);
    wr(A_SAMP, 64'h10);
    rd_chk("R7 sampling bit4 dropped", A_INUSE, 64'h0);
  endtask

  task automatic t_inuse_ro();
    clear_cfg();
    wr(A_EVSEL + 12'd1, 64'h5);
    wr(A_FXCTL, 64'h1);
    wr(A_INUSE, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R8 status after write", A_INUSE, 64'h0000_0001_0000_0002);
    rd_chk("R8 evsel1 intact", A_EVSEL + 12'd1, 64'h5);
    rd_chk("R8 fixed ctl intact", A_FXCTL, 64'h1);
  endtask

  task automatic t_count();
    clear_cfg();
    cap = 1;
    wr(A_EVSEL, 64'h3C);
    wr(A_ALIAS, 64'h0000_FFFF_FFFF_FFFF);
    pulse(4'b0001, 3'b000);
    rd_chk("R9 wrap to zero", A_GP, 64'h0);
    pulse(4'b0001, 3'b000);
    rd_chk("R9 step after wrap", A_GP, 64'h1);
    wr(A_GP + 12'd3, 64'h10);
    pulse(4'b1000, 3'b000);
    rd_chk("R9 disabled counter holds", A_GP + 12'd3, 64'h10);
    wr(A_FXCTL, 64'h1);
    wr(A_FX, 64'h7);
    wr(A_FX + 12'd1, 64'h20);
    pulse(4'b0000, 3'b011);
    rd_chk("R9 fixed0 counts", A_FX, 64'h8);
    rd_chk("R9 fixed1 disabled holds", A_FX + 12'd1, 64'h20);
    cap = 0;
  endtask

  task automatic t_priority();
    clear_cfg();
    wr(A_EVSEL, 64'h1);
    @(negedge clk); wr_en = 1; addr = A_GP; wdata = 64'h55; gp_evt = 4'b0001;
    @(negedge clk); wr_en = 0; gp_evt = '0;
    rd_chk("R10 write beats strobe", A_GP, 64'h55);
    pulse(4'b0001, 3'b000);
    rd_chk("R10 strobe alone then counts", A_GP, 64'h56);
  endtask

  task automatic t_read();
    logic [63:0] v;
    rd_chk("R11 unmapped reads zero", 12'h7FF, 64'h0);
    rd(A_GP, v);
    @(negedge clk); addr = 12'h7FF;
    @(negedge clk);
    check("R11 rdata holds without rd_en", rdata, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_legacy();
    t_alias_on();
    t_alias_off();
    t_inuse_gp();
    t_inuse_fx();
    t_inuse_ro();
    t_count();
    t_priority();
    t_read();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    total++;
    bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule